// File: doc/BRIEF.md
# Register-Programmed PWM Channel Bank

This block produces up to four independent pulse-width-modulated outputs, each set up through a single 32-bit control word. The word for a channel sits at byte address `channel × 16` on a plain synchronous register port. Writes take effect on the clock edge at which `reg_wr` is high. Read data is returned combinationally for the address currently presented.

Each channel has a prescaler that stretches every duty tick to `scale + 1` source clocks. A 256-step tick counter spans one output period. The output is high while the tick position is below the programmed duty. A separate full-on bit holds the output high for the whole period. The enable bit starts the channel and stops it.

Any write to a channel restarts that channel's counters. New settings therefore apply at once, and disabling drops the output with no wait for the period in progress to finish. Software selects the period through `scale` and the pulse width through `duty`. It sets the full-on bit when it needs exactly 100 % duty.

Top module: `pwm_bank`

## Requirements
- R1: Asserting `rst_n` low clears every channel word to zero and drives all outputs low at once; after release every channel reads 0.
- R2: A channel's word sits at byte address `16 × index` for index below `NUM_CH`. A write to any other address, including one whose low four bits are non-zero, changes no channel. Reads of such addresses return 0.
- R3: The stored fields are bit 31 (enable), bit 24 (full-on), bits 23:16 (duty) and bits 12:0 (scale). All other bits read back as 0 whatever was written.
- R4: Every tick lasts `scale + 1` clocks, and one period is 256 ticks (`256 × (scale + 1)` clocks). The pattern repeats identically in following periods.
- R5: With enable set and full-on clear, the output is high for the first `duty` ticks of each period and low for the rest. A duty of 0 keeps it low throughout.
- R6: With enable and full-on both set, the output is high for the entire period and the duty field has no effect.
- R7: A write that clears the enable bit drives the output low from the cycle after the write and keeps it low.
- R8: Any write to a channel restarts its prescaler and tick counter. The new pattern begins in the cycle after the write, high first when duty is non-zero or full-on is set.
- R9: A write to one channel does not disturb the output pattern or settings of any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| reg_addr | input | ADDR_W (6) | Byte address of the register access |
| reg_wr | input | 1 | Write strobe, one clock per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pwm_out | output | NUM_CH (4) | One PWM output per channel, active high |

## Verification
The hardest situation to reach from the ports is a reprogram or a disable that lands part-way through a period while other channels keep running. In that case the restart must cut the old pattern off cleanly, with no leftover tick phase carried over.

To reach it, the stimulus lets channel 0 run for a known number of cycles and then writes a neighbouring channel. It counts how many high cycles channel 0 still shows in the rest of its period. It then rewrites channel 0 forty cycles into a fresh period. The position of the first low sample afterwards shows whether both counters restarted.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

  localparam int REG_W     = 32;
  localparam int SCALE_W   = 13;
  localparam int DUTY_W    = 8;
  localparam int EN_BIT    = 31;
  localparam int FULL_BIT  = 24;
  localparam int DUTY_LSB  = 16;
  localparam int SCALE_LSB = 0;

  typedef struct packed {
    logic               en;
    logic               full;
    logic [DUTY_W-1:0]  duty;
    logic [SCALE_W-1:0] scale;
  } pwm_cfg_t;

  localparam int CFG_W = $bits(pwm_cfg_t);

  // Bits that hold state; everything else reads as zero.
  localparam logic [REG_W-1:0] RW_MASK =
      (REG_W'(1) << EN_BIT) | (REG_W'(1) << FULL_BIT) |
      (REG_W'((1 << DUTY_W) - 1) << DUTY_LSB) |
      (REG_W'((1 << SCALE_W) - 1) << SCALE_LSB);

  function automatic pwm_cfg_t cfg_from_word(input logic [REG_W-1:0] w);
    pwm_cfg_t c;
    c.en    = w[EN_BIT];
    c.full  = w[FULL_BIT];
    c.duty  = w[DUTY_LSB +: DUTY_W];
    c.scale = w[SCALE_LSB +: SCALE_W];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] cfg_to_word(input pwm_cfg_t c);
    logic [REG_W-1:0] w;
    w                        = '0;
    w[EN_BIT]                = c.en;
    w[FULL_BIT]              = c.full;
    w[DUTY_LSB +: DUTY_W]    = c.duty;
    w[SCALE_LSB +: SCALE_W]  = c.scale;
    return w;
  endfunction

endpackage

// File: rtl/pwm_chan_reg.sv
module pwm_chan_reg
  import pwm_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [REG_W-1:0] wdata,
  output pwm_cfg_t         cfg_o
);

  pwm_cfg_t cfg_q;
  pwm_cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_stb) cfg_d = cfg_from_word(wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (wr_stb) cfg_q <= cfg_d;
  end

  assign cfg_o = cfg_q;

endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         restart,
  input  logic [W-1:0] limit,
  output logic         tick_o
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         at_lim;

  assign at_lim = (cnt_q == limit);
  assign tick_o = run && !restart && at_lim;

  always_comb begin
    if (restart || !run) cnt_d = '0;
    else if (at_lim)     cnt_d = '0;
    else                 cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // The prescale count never passes the programmed limit while running.
  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= limit));

  // A restart leaves the prescaler at zero.
  assert_restart_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));

endmodule

// File: rtl/pwm_period_cnt.sv
module pwm_period_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         restart,
  input  logic         tick,
  output logic [W-1:0] pos_o
);

  logic [W-1:0] pos_q;
  logic [W-1:0] pos_d;

  always_comb begin
    if (restart || !run) pos_d = '0;
    else if (tick)       pos_d = pos_q + W'(1);
    else                 pos_d = pos_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  assign pos_o = pos_q;

  // The last tick of a period wraps to the first.
  assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !restart && tick && (pos_q == {W{1'b1}})) |=> (pos_q == '0));

  // The position only advances on a prescaler tick.
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !restart && !tick) |=> $stable(pos_q));

  assert_restart_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (pos_q == '0));

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [REG_W-1:0] wdata,
  output pwm_cfg_t         cfg_o,
  output logic             pwm_o
);

  pwm_cfg_t          cfg;
  logic              tick;
  logic [DUTY_W-1:0] pos;

  pwm_chan_reg u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_stb (wr_stb),
    .wdata  (wdata),
    .cfg_o  (cfg)
  );

  pwm_prescaler #(.W(SCALE_W)) u_psc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (cfg.en),
    .restart (wr_stb),
    .limit   (cfg.scale),
    .tick_o  (tick)
  );

  pwm_period_cnt #(.W(DUTY_W)) u_pos (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (cfg.en),
    .restart (wr_stb),
    .tick    (tick),
    .pos_o   (pos)
  );

  always_comb begin
    pwm_o = cfg.en && (cfg.full || (pos < cfg.duty));
  end

  assign cfg_o = cfg;

  assert_disable_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !wdata[EN_BIT]) |=> !pwm_o);

  assert_restart_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wdata[EN_BIT] &&
     (wdata[FULL_BIT] || (wdata[DUTY_LSB +: DUTY_W] != '0))) |=> pwm_o);

  assert_zero_duty_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.full && (cfg.duty == '0)) |-> !pwm_o);

  assert_full_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.en && cfg.full) |-> pwm_o);

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic [NUM_CH-1:0] pwm_out
);

  localparam int SLOT_LSB = 4;
  localparam int IDX_W    = ADDR_W - SLOT_LSB;

  logic                    slot_aligned;
  logic [IDX_W-1:0]        slot_idx;
  logic [NUM_CH-1:0]       sel;
  logic [NUM_CH-1:0]       wr_stb;
  pwm_cfg_t                cfg_arr [NUM_CH];
  logic [NUM_CH*CFG_W-1:0] cfg_flat;

  assign slot_aligned = (reg_addr[SLOT_LSB-1:0] == '0);
  assign slot_idx     = reg_addr[ADDR_W-1:SLOT_LSB];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    assign sel[ch]    = slot_aligned && (slot_idx == IDX_W'(ch));
    assign wr_stb[ch] = reg_wr && sel[ch];

    pwm_channel u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_stb (wr_stb[ch]),
      .wdata  (reg_wdata),
      .cfg_o  (cfg_arr[ch]),
      .pwm_o  (pwm_out[ch])
    );

    assign cfg_flat[ch*CFG_W +: CFG_W] = cfg_arr[ch];
  end

  always_comb begin
    reg_rdata = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (sel[c]) reg_rdata = cfg_to_word(cfg_arr[c]);
    end
  end

  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_rdata & ~RW_MASK) == '0));

  assert_unmapped_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (wr_stb == '0)) |=> $stable(cfg_flat));

  assert_single_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_stb));

endmodule

// File: tb/pwm_bank_bench.sv
`timescale 1ns/1ps
module pwm_bank_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  reg_addr;
  logic        reg_wr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [3:0]  pwm_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pwm_bank u_pwm_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pwm_out   (pwm_out)
  );

  // {control word, expected high clocks per period, period in clocks}
  localparam logic [63:0] VEC [8] = '{
    {32'h8000_0000, 16'd0,    16'd256},
    {32'h8080_0000, 16'd128,  16'd256},
    {32'h80FF_0000, 16'd255,  16'd256},
    {32'h8105_0000, 16'd256,  16'd256},
    {32'h800A_0002, 16'd30,   16'd768},
    {32'h8001_0001, 16'd2,    16'd512},
    {32'h8100_0003, 16'd1024, 16'd1024},
    {32'h80C8_0004, 16'd1000, 16'd1280}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the next negedge, the first cycle after the write.
  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic measure(input int ch, input int len, output int high, output int first_low);
    high      = 0;
    first_low = len;
    for (int i = 0; i < len; i++) begin
      if (pwm_out[ch]) high++;
      else if (first_low == len) first_low = i;
      @(negedge clk);
    end
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] w;
    int h;
    int fl;
    rst_n     = 1'b0;
    reg_wr    = 1'b0;
    reg_addr  = '0;
    reg_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 out in reset", {28'd0, pwm_out}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: every channel word is zero after reset
    for (int c = 0; c < 4; c++) begin
      rd(6'(c * 16), d);
      chk("R1 reset word", d, 32'd0);
    end
    chk("R1 out after reset", {28'd0, pwm_out}, 32'd0);
    @(negedge clk);

    // Vector table on channel 0: R4, R5, R6, R3
    for (int v = 0; v < 8; v++) begin
      w = VEC[v][63:32];
      wr(6'h00, w);
      measure(0, int'(VEC[v][15:0]), h, fl);
      chk("R5/R6 high count", 32'(h), 32'(VEC[v][31:16]));
      chk("R4 tick length", 32'(fl), 32'(VEC[v][31:16]));
      measure(0, int'(VEC[v][15:0]), h, fl);
      chk("R4 repeat period", 32'(h), 32'(VEC[v][31:16]));
      rd(6'h00, d);
      chk("R3 readback", d, w);
      @(negedge clk);
    end

    // R3 and R6: reserved bits dropped, full-on overrides duty
    wr(6'h10, 32'hFFFF_FFFF);
    chk("R6 full on", {31'd0, pwm_out[1]}, 32'd1);
    rd(6'h10, d);
    chk("R3 reserved bits", d, 32'h81FF_1FFF);
    @(negedge clk);

    // R2: unmapped and misaligned addresses
    wr(6'h00, 32'h8000_0005);
    wr(6'h04, 32'h80FF_0000);
    wr(6'h18, 32'h8000_0000);
    rd(6'h00, d);
    chk("R2 ch0 untouched", d, 32'h8000_0005);
    rd(6'h10, d);
    chk("R2 ch1 untouched", d, 32'h81FF_1FFF);
    rd(6'h04, d);
    chk("R2 misaligned read", d, 32'd0);
    rd(6'h18, d);
    chk("R2 misaligned read", d, 32'd0);
    @(negedge clk);

    // R9: writing channel 2 mid-period leaves channel 0 running
    wr(6'h00, 32'h8080_0000);
    measure(0, 10, h, fl);
    chk("R9 before neighbour write", 32'(h), 32'd10);
    wr(6'h20, 32'h8100_0000);
    measure(0, 245, h, fl);
    chk("R9 rest of period", 32'(h), 32'd117);
    chk("R9 ch2 running", {31'd0, pwm_out[2]}, 32'd1);

    // R8: reprogram forty cycles into a new period
    measure(0, 40, h, fl);
    wr(6'h00, 32'h8014_0000);
    measure(0, 256, h, fl);
    chk("R8 restart first low", 32'(fl), 32'd20);
    chk("R8 restart high count", 32'(h), 32'd20);

    // R7: disable stops the output at once
    wr(6'h00, 32'h8100_0000);
    chk("R7 running before", {31'd0, pwm_out[0]}, 32'd1);
    measure(0, 5, h, fl);
    wr(6'h00, 32'h0100_0000);
    measure(0, 20, h, fl);
    chk("R7 disabled low", 32'(h), 32'd0);
    rd(6'h00, d);
    chk("R7 word kept", d, 32'h0100_0000);
    @(negedge clk);

    // R1: reset while running
    chk("R1 running before", {30'd0, pwm_out[2:1]}, 32'd3);
    rst_n = 1'b0;
    #1;
    chk("R1 async clear", {28'd0, pwm_out}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int c = 0; c < 4; c++) begin
      rd(6'(c * 16), d);
      chk("R1 cleared word", d, 32'd0);
    end
    chk("R1 outputs low", {28'd0, pwm_out}, 32'd0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule